// File: doc/BRIEF.md
# Single-Bank SDRAM Read Sequencer

This block owns the state of one SDRAM bank and turns read requests into the command stream the bank needs. A request carries a row, a column and an auto-close flag, and arrives over a valid/ready handshake. The sequencer decides whether the bank must first be opened, or closed and reopened on another row. It spaces the commands by the activate-to-read and precharge-to-activate delays. It also predicts the cycles in which the read burst will be on the data pins.

The data-valid window starts a fixed CAS latency after the read command. It lasts half the burst length in clocks, because data moves on both strobe edges. An explicit precharge request closes the bank and cuts a running burst short. A read with auto-close returns the bank to idle by itself. While that happens the bank is locked, and any request or precharge made during the lock is refused and flagged. A busy input from a refresh manager holds off new requests.

Top module: `ddr_rdseq`

## Requirements
- R1: After reset, cmd_o is NOP (code 0), rd_valid_o and err_o are 0, and req_ready_o is 1 while busy_i is 0.
- R2: A request accepted while the bank is idle produces ACT (code 1) with the request row in the cycle after acceptance. READ (code 2) with the request column follows exactly T_RCD cycles after the ACT, and no READ is ever issued to a bank that has not been activated.
- R3: rd_valid_o rises exactly CL cycles after the cycle showing READ or READ_AP and stays high for exactly BL/2 consecutive cycles.
- R4: A request to the open row while the bank is open and quiet produces READ in the cycle after acceptance, with no ACT.
- R5: A request to a different row while the bank is open produces PRE (code 4) in the cycle after acceptance, then ACT with the new row T_RP cycles after PRE, then READ T_RCD cycles after the ACT.
- R6: pre_req_i while the bank is open produces PRE in the next cycle. The bank is then idle, so the next request produces ACT.
- R7: pre_req_i during a normal read produces PRE in the next cycle, and rd_valid_o is 0 from that cycle until the next read.
- R8: A request with auto-close set produces READ_AP (code 3). req_ready_o stays 0 until CL + BL/2 + T_RP cycles after the READ_AP cycle, and the next request then needs ACT.
- R9: req_valid_i or pre_req_i held during the auto-close lock makes err_o 1 in the following cycle, and no command is issued.
- R10: While busy_i is 1, req_ready_o is 0 and no request is accepted.
- R11: pre_req_i while the bank is idle issues no command and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Read request accepted when high with valid |
| req_row_i | input | ROW_W | Request row address |
| req_col_i | input | COL_W | Request column address |
| req_ap_i | input | 1 | Close the bank after this read |
| pre_req_i | input | 1 | Explicit precharge request |
| busy_i | input | 1 | Refresh manager holds off new requests |
| cmd_o | output | 3 | Command: 0 NOP, 1 ACT, 2 READ, 3 READ_AP, 4 PRE |
| cmd_row_o | output | ROW_W | Row carried with ACT |
| cmd_col_o | output | COL_W | Column carried with READ or READ_AP |
| rd_valid_o | output | 1 | Predicted read-data window |
| err_o | output | 1 | Command attempted during auto-close lock |

## Verification
The bench measures the cycle distances ACT to READ, PRE to ACT and READ to first data beat. An off-by-one in any timer shows up there as a command one cycle early or late. A precharge raised on the second data beat must end the window at once. A design that let the window run to its natural end would show valid beats after PRE. During an auto-close read the bench pushes both a request and a precharge. A design without the lock would issue PRE, or reopen the bank early, instead of flagging an error. The bench also checks the cycle in which ready returns against latency plus burst plus precharge time.

// File: rtl/ddr_rdseq_pkg.sv
package ddr_rdseq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_RDA = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_ACT_WAIT = 3'd1,
    ST_OPEN     = 3'd2,
    ST_READ     = 3'd3,
    ST_AP_WAIT  = 3'd4,
    ST_PRE_WAIT = 3'd5
  } bank_st_e;

endpackage

// File: rtl/ddr_rdseq_timer.sv
module ddr_rdseq_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);

  // counter only moves down unless reloaded
  assert_timer_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_o == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ddr_rdseq_req_hold.sv
module ddr_rdseq_req_hold #(
  parameter int ROW_W = 13,
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             ap_i,
  input  logic             open_i,
  input  logic [ROW_W-1:0] open_row_i,
  output logic [ROW_W-1:0] hold_row_o,
  output logic [COL_W-1:0] hold_col_o,
  output logic             hold_ap_o,
  output logic [ROW_W-1:0] open_row_o
);

  logic [ROW_W-1:0] row_q, open_q;
  logic [COL_W-1:0] col_q;
  logic             ap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      col_q <= '0;
      ap_q  <= 1'b0;
    end else if (capture_i) begin
      row_q <= row_i;
      col_q <= col_i;
      ap_q  <= ap_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     open_q <= '0;
    else if (open_i) open_q <= open_row_i;
  end

  assign hold_row_o = row_q;
  assign hold_col_o = col_q;
  assign hold_ap_o  = ap_q;
  assign open_row_o = open_q;

endmodule

// File: rtl/ddr_rdseq.sv
module ddr_rdseq
  import ddr_rdseq_pkg::*;
#(
  parameter int ROW_W = 13,
  parameter int COL_W = 10,
  parameter int T_RCD = 3,
  parameter int T_RP  = 3,
  parameter int CL    = 3,
  parameter int BL    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic             req_ap_i,
  input  logic             pre_req_i,
  input  logic             busy_i,
  output logic [2:0]       cmd_o,
  output logic [ROW_W-1:0] cmd_row_o,
  output logic [COL_W-1:0] cmd_col_o,
  output logic             rd_valid_o,
  output logic             err_o
);

  localparam int BURST = BL / 2;
  localparam int WIN   = CL + BURST;
  localparam int MAXA  = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int MAXC  = (WIN > MAXA) ? WIN : MAXA;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_WIN = CNT_W'(WIN - 1);
  localparam logic [CNT_W-1:0] BURST_C = CNT_W'(BURST);

  bank_st_e         st_q, st_n;
  cmd_e             cmd_q, cmd_n;
  logic [ROW_W-1:0] row_q, row_n;
  logic [COL_W-1:0] col_q, col_n;
  logic             pend_q, pend_n;
  logic             err_q;

  logic             load, zero;
  logic [CNT_W-1:0] load_val, cnt;
  logic             open_set;
  logic [ROW_W-1:0] open_row_new;
  logic [ROW_W-1:0] hold_row, open_row;
  logic [COL_W-1:0] hold_col;
  logic             hold_ap;
  logic             accept, row_hit, lock;

  assign lock    = (st_q == ST_AP_WAIT) || ((st_q == ST_READ) && hold_ap);
  assign req_ready_o = !busy_i &&
                       ((st_q == ST_IDLE) || ((st_q == ST_OPEN) && !pre_req_i));
  assign accept  = req_valid_i && req_ready_o;
  assign row_hit = (open_row == req_row_i);

  ddr_rdseq_timer #(.W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .cnt_o      (cnt),
    .zero_o     (zero)
  );

  ddr_rdseq_req_hold #(.ROW_W(ROW_W), .COL_W(COL_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (accept),
    .row_i      (req_row_i),
    .col_i      (req_col_i),
    .ap_i       (req_ap_i),
    .open_i     (open_set),
    .open_row_i (open_row_new),
    .hold_row_o (hold_row),
    .hold_col_o (hold_col),
    .hold_ap_o  (hold_ap),
    .open_row_o (open_row)
  );

  always_comb begin
    st_n         = st_q;
    cmd_n        = CMD_NOP;
    row_n        = row_q;
    col_n        = col_q;
    pend_n       = pend_q;
    load         = 1'b0;
    load_val     = '0;
    open_set     = 1'b0;
    open_row_new = hold_row;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          cmd_n        = CMD_ACT;
          row_n        = req_row_i;
          open_set     = 1'b1;
          open_row_new = req_row_i;
          load         = 1'b1;
          load_val     = LD_RCD;
          st_n         = ST_ACT_WAIT;
        end
      end
      ST_ACT_WAIT: begin
        if (zero) begin
          cmd_n    = hold_ap ? CMD_RDA : CMD_RD;
          col_n    = hold_col;
          load     = 1'b1;
          load_val = LD_WIN;
          st_n     = ST_READ;
        end
      end
      ST_OPEN: begin
        if (pre_req_i) begin
          cmd_n    = CMD_PRE;
          pend_n   = 1'b0;
          load     = 1'b1;
          load_val = LD_RP;
          st_n     = ST_PRE_WAIT;
        end else if (accept) begin
          if (row_hit) begin
            cmd_n    = req_ap_i ? CMD_RDA : CMD_RD;
            col_n    = req_col_i;
            load     = 1'b1;
            load_val = LD_WIN;
            st_n     = ST_READ;
          end else begin
            cmd_n    = CMD_PRE;
            pend_n   = 1'b1;
            load     = 1'b1;
            load_val = LD_RP;
            st_n     = ST_PRE_WAIT;
          end
        end
      end
      ST_READ: begin
        if (!hold_ap && pre_req_i) begin
          // precharge cuts the burst
          cmd_n    = CMD_PRE;
          pend_n   = 1'b0;
          load     = 1'b1;
          load_val = LD_RP;
          st_n     = ST_PRE_WAIT;
        end else if (zero) begin
          if (hold_ap) begin
            load     = 1'b1;
            load_val = LD_RP;
            st_n     = ST_AP_WAIT;
          end else begin
            st_n     = ST_OPEN;
          end
        end
      end
      ST_AP_WAIT: begin
        if (zero) st_n = ST_IDLE;
      end
      ST_PRE_WAIT: begin
        if (zero) begin
          if (pend_q) begin
            cmd_n    = CMD_ACT;
            row_n    = hold_row;
            open_set = 1'b1;
            pend_n   = 1'b0;
            load     = 1'b1;
            load_val = LD_RCD;
            st_n     = ST_ACT_WAIT;
          end else begin
            st_n     = ST_IDLE;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cmd_q  <= CMD_NOP;
      row_q  <= '0;
      col_q  <= '0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      cmd_q  <= cmd_n;
      row_q  <= row_n;
      col_q  <= col_n;
      pend_q <= pend_n;
      err_q  <= lock && (req_valid_i || pre_req_i);
    end
  end

  assign cmd_o      = cmd_q;
  assign cmd_row_o  = row_q;
  assign cmd_col_o  = col_q;
  assign rd_valid_o = (st_q == ST_READ) && (cnt < BURST_C);
  assign err_o      = err_q;

  // ---------------- checks ----------------
  logic [CNT_W-1:0] since_act_q;
  logic             act_seen_q;
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act_q <= '0;
      act_seen_q  <= 1'b0;
      run_q       <= '0;
    end else begin
      if (cmd_q == CMD_ACT)                since_act_q <= CNT_W'(1);
      else if (since_act_q < CNT_W'(T_RCD)) since_act_q <= since_act_q + 1'b1;
      if (cmd_q == CMD_ACT)                              act_seen_q <= 1'b1;
      else if (cmd_q == CMD_PRE || cmd_q == CMD_RDA)     act_seen_q <= 1'b0;
      if (rd_valid_o) run_q <= run_q + 1'b1;
      else            run_q <= '0;
    end
  end

  assert_read_after_act_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_RD || cmd_q == CMD_RDA) |-> (act_seen_q && since_act_q >= CNT_W'(T_RCD)));

  assert_window_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (run_q < BURST_C));

  assert_pre_ends_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_PRE) |-> !rd_valid_o);

  assert_lock_no_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |-> !req_ready_o);

  assert_lock_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> (cmd_q == CMD_NOP));

  assert_busy_holds_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !req_ready_o);

endmodule

// File: tb/ddr_rdseq_bench.sv
module ddr_rdseq_bench;

  localparam int ROW_W = 13;
  localparam int COL_W = 10;
  localparam int T_RCD = 3;
  localparam int T_RP  = 3;
  localparam int CL    = 3;
  localparam int BL    = 8;
  localparam int BURST = BL / 2;

  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_RDA = 3, C_PRE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ap = 1'b0;
  logic pre_req = 1'b0;
  logic busy = 1'b0;
  logic [2:0] cmd;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic rd_valid;
  logic err;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_rdseq #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RP(T_RP),
              .CL(CL), .BL(BL)) u_ddr_rdseq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .req_row_i   (req_row),
    .req_col_i   (req_col),
    .req_ap_i    (req_ap),
    .pre_req_i   (pre_req),
    .busy_i      (busy),
    .cmd_o       (cmd),
    .cmd_row_o   (cmd_row),
    .cmd_col_o   (cmd_col),
    .rd_valid_o  (rd_valid),
    .err_o       (err)
  );

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cmd(int code, int maxc, output int at);
    at = -1;
    for (int i = 0; i < maxc; i++) begin
      step();
      if (int'(cmd) == code) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic window(output int first, output int len);
    first = -1;
    len = 0;
    for (int i = 0; i < CL + BURST + 4; i++) begin
      step();
      if (rd_valid) begin
        if (first < 0) first = cyc;
        len++;
      end
    end
  endtask

  task automatic send(int row, int col, bit ap);
    req_valid = 1'b1;
    req_row = ROW_W'(row);
    req_col = COL_W'(col);
    req_ap = ap;
    step();
    req_valid = 1'b0;
    req_ap = 1'b0;
  endtask

  task automatic t_reset();
    chk(int'(cmd) == C_NOP, "R1 cmd", int'(cmd), C_NOP);
    chk(rd_valid == 1'b0, "R1 rd_valid", int'(rd_valid), 0);
    chk(err == 1'b0, "R1 err", int'(err), 0);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
  endtask

  task automatic t_idle_read();
    int a, r, f, l;
    send(5, 9, 1'b0);
    a = cyc;
    chk(int'(cmd) == C_ACT, "R2 ACT after accept", int'(cmd), C_ACT);
    chk(int'(cmd_row) == 5, "R2 ACT row", int'(cmd_row), 5);
    wait_cmd(C_RD, 10, r);
    chk(r - a == T_RCD, "R2 ACT to READ", r - a, T_RCD);
    chk(int'(cmd_col) == 9, "R2 READ col", int'(cmd_col), 9);
    window(f, l);
    chk(f - r == CL, "R3 latency", f - r, CL);
    chk(l == BURST, "R3 burst length", l, BURST);
  endtask

  task automatic t_row_hit();
    int r, f, l;
    send(5, 3, 1'b0);
    r = cyc;
    chk(int'(cmd) == C_RD, "R4 hit READ", int'(cmd), C_RD);
    chk(int'(cmd_col) == 3, "R4 hit col", int'(cmd_col), 3);
    window(f, l);
    chk(f - r == CL, "R3 hit latency", f - r, CL);
    chk(l == BURST, "R3 hit burst", l, BURST);
  endtask

  task automatic t_row_miss();
    int p, a, r;
    send(7, 2, 1'b0);
    p = cyc;
    chk(int'(cmd) == C_PRE, "R5 miss PRE", int'(cmd), C_PRE);
    wait_cmd(C_ACT, 10, a);
    chk(a - p == T_RP, "R5 PRE to ACT", a - p, T_RP);
    chk(int'(cmd_row) == 7, "R5 new row", int'(cmd_row), 7);
    wait_cmd(C_RD, 10, r);
    chk(r - a == T_RCD, "R5 ACT to READ", r - a, T_RCD);
    step(CL + BURST + 2);
  endtask

  task automatic t_pre_mid_burst();
    int extra;
    send(7, 1, 1'b0);
    chk(int'(cmd) == C_RD, "R7 setup READ", int'(cmd), C_RD);
    step(CL);
    chk(rd_valid == 1'b1, "R7 first beat", int'(rd_valid), 1);
    step();
    pre_req = 1'b1;
    step();
    pre_req = 1'b0;
    chk(int'(cmd) == C_PRE, "R7 PRE mid burst", int'(cmd), C_PRE);
    chk(rd_valid == 1'b0, "R7 window cut", int'(rd_valid), 0);
    extra = 0;
    for (int i = 0; i < 8; i++) begin
      step();
      if (rd_valid) extra++;
    end
    chk(extra == 0, "R7 no beats after PRE", extra, 0);
  endtask

  task automatic t_explicit_pre();
    int r;
    send(2, 8, 1'b0);
    chk(int'(cmd) == C_ACT, "R6 setup ACT", int'(cmd), C_ACT);
    wait_cmd(C_RD, 10, r);
    step(CL + BURST + 2);
    pre_req = 1'b1;
    step();
    pre_req = 1'b0;
    chk(int'(cmd) == C_PRE, "R6 explicit PRE", int'(cmd), C_PRE);
    step(T_RP + 2);
    send(2, 8, 1'b0);
    chk(int'(cmd) == C_ACT, "R6 idle after PRE", int'(cmd), C_ACT);
    wait_cmd(C_RD, 10, r);
    step(CL + BURST + 2);
  endtask

  task automatic t_auto_pre();
    int r, rdy;
    send(2, 4, 1'b1);
    r = cyc;
    chk(int'(cmd) == C_RDA, "R8 READ_AP code", int'(cmd), C_RDA);
    step();
    pre_req = 1'b1;
    step();
    pre_req = 1'b0;
    chk(err == 1'b1, "R9 err on PRE in lock", int'(err), 1);
    chk(int'(cmd) == C_NOP, "R9 no cmd on PRE", int'(cmd), C_NOP);
    req_valid = 1'b1;
    req_row = ROW_W'(9);
    step();
    req_valid = 1'b0;
    chk(err == 1'b1, "R9 err on req in lock", int'(err), 1);
    chk(int'(cmd) == C_NOP, "R9 no cmd on req", int'(cmd), C_NOP);
    step();
    chk(err == 1'b0, "R9 err clears", int'(err), 0);
    rdy = -1;
    for (int i = 0; i < 30; i++) begin
      if (req_ready) begin
        rdy = cyc;
        break;
      end
      step();
    end
    chk(rdy - r == CL + BURST + T_RP, "R8 lock length", rdy - r, CL + BURST + T_RP);
    send(2, 4, 1'b0);
    chk(int'(cmd) == C_ACT, "R8 closed after AP", int'(cmd), C_ACT);
    wait_cmd(C_RD, 10, r);
    step(CL + BURST + 2);
  endtask

  task automatic t_busy();
    int bad;
    busy = 1'b1;
    step();
    chk(req_ready == 1'b0, "R10 ready low", int'(req_ready), 0);
    req_valid = 1'b1;
    req_row = ROW_W'(2);
    req_col = COL_W'(6);
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      if (int'(cmd) != C_NOP) bad++;
    end
    chk(bad == 0, "R10 nothing issued", bad, 0);
    busy = 1'b0;
    step();
    req_valid = 1'b0;
    chk(int'(cmd) == C_RD, "R10 accepted after busy", int'(cmd), C_RD);
    chk(int'(cmd_col) == 6, "R10 col", int'(cmd_col), 6);
    step(CL + BURST + 2);
  endtask

  task automatic t_pre_idle();
    pre_req = 1'b1;
    step();
    pre_req = 1'b0;
    step(T_RP + 2);
    pre_req = 1'b1;
    step();
    pre_req = 1'b0;
    chk(int'(cmd) == C_NOP, "R11 no cmd", int'(cmd), C_NOP);
    chk(err == 1'b0, "R11 no err", int'(err), 0);
    step();
    chk(int'(cmd) == C_NOP, "R11 still quiet", int'(cmd), C_NOP);
    send(4, 0, 1'b0);
    chk(int'(cmd) == C_ACT, "R11 bank stays idle", int'(cmd), C_ACT);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    t_reset();
    t_idle_read();
    t_row_hit();
    t_row_miss();
    t_pre_mid_burst();
    t_explicit_pre();
    t_auto_pre();
    t_busy();
    t_pre_idle();
    step(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule